// File: doc/BRIEF.md
# Ring-Loop PUF Measurement Controller

This block drives a ring oscillator made of NCH identical delay chains and turns its timing into a device identity. Each chain takes an MW-bit word, and each bit of a word picks the delay of one element in that chain. A challenge holds NCH such words. On a start pulse the controller latches the challenge. It then drives the chains with every cyclic rotation of the words, one rotation at a time. For each rotation it counts system clock cycles across a fixed number of loop periods. When all rotations are measured, it compares neighbouring measurements in a ring and outputs one identity bit per comparison.

The loop output enters through a two-flop synchronizer, and window edges are taken from rising edges of the synchronized signal. After the words change, a set number of edges is discarded so that the loop can settle. The last discarded edge opens the window. There is no data stream here, so no valid/ready pair is used. The challenge is the only incoming data and it is taken with a plain start strobe. Back-pressure takes the form of busy: a start while busy is dropped, and a caller must wait for busy to fall before it issues the next challenge.

Top module: `loopid_ctrl`

## Requirements
- R1: While reset is asserted (rst_n low), busy, done, id and ctrl_words are all zero.
- R2: A start seen while idle latches chal, where word i sits at bits [i*MW +: MW]. At the next clock edge busy rises, and ctrl_words then equals chal unrotated.
- R3: During rotation k (k = 0..NCH-1, in increasing order), chain i, at bits [i*MW +: MW] of ctrl_words, receives word (i+k) mod NCH. ctrl_words changes only when one rotation ends and the next begins.
- R4: Each measurement is taken on rising edges of the two-flop-synchronized loop signal. SKIP edges are discarded after each word change. The measurement is the number of system clock cycles from the last discarded edge to the WIN-th edge after it, which equals WIN times the loop period in system cycles. The CW-bit counter never reaches all ones while counting.
- R5: For NCH > 2, id bit k is 1 exactly when measurement k is strictly greater than measurement (k+1) mod NCH. Equal measurements give 0.
- R6: For NCH = 2, id is a single bit, which is 1 exactly when the measurement with words (C0, C1) is strictly greater than the measurement with words (C1, C0).
- R7: done is a one-cycle pulse in the cycle where busy has just fallen. id changes only together with done and holds its value until the next done.
- R8: A start while busy is ignored. The latched challenge, the rotation sequence and the resulting id are those of the challenge already accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Strobe that accepts chal when idle |
| chal | input | NCH*MW | Challenge words; word i at bits [i*MW +: MW] |
| loop_osc | input | 1 | Oscillating loop output, asynchronous to clk |
| ctrl_words | output | NCH*MW | Words applied to the delay chains; chain i at bits [i*MW +: MW] |
| busy | output | 1 | High from acceptance until the identity is ready |
| done | output | 1 | One-cycle pulse when id is updated |
| id | output | IDW | Identity bits (IDW = 1 for NCH = 2, else NCH) |

## Verification
busy and the unrotated ctrl_words are due at the first clock edge after start is sampled, so the bench checks them at the following falling edge. The time to done is not fixed. It depends on the loop period of each rotation, the synchronizer delay and the SKIP settling edges. For that reason the monitor does not count cycles. It waits for the done pulse, pops the expected id from a scoreboard queue and compares it in the same falling-edge sample. It also tracks every ctrl_words change while busy against the next expected rotation, and checks id again several cycles after done to confirm that it holds.

// File: rtl/loopid_pkg.sv
package loopid_pkg;
  typedef enum logic [1:0] {C_IDLE, C_MEAS, C_FIN} ctl_st_t;
  typedef enum logic [1:0] {W_IDLE, W_SKIP, W_COUNT} win_st_t;
endpackage

// File: rtl/loopid_sync.sv
module loopid_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_async,
  output logic rise
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], osc_async};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];

  // R4: a rising edge can never be reported on two cycles in a row
  p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/loopid_window.sv
module loopid_window
  import loopid_pkg::*;
#(
  parameter int WIN  = 8,
  parameter int SKIP = 2,
  parameter int CW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          rise,
  output logic          fin,
  output logic [CW-1:0] val
);
  localparam int ECW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int SCW = $clog2(SKIP + 1);

  win_st_t          st;
  logic [SCW-1:0]   skip_c;
  logic [ECW-1:0]   edge_c;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= W_IDLE;
      skip_c <= '0;
      edge_c <= '0;
      cnt    <= '0;
      fin    <= 1'b0;
      val    <= '0;
    end else begin
      fin <= 1'b0;
      case (st)
        W_IDLE: begin
          if (arm) begin
            st     <= W_SKIP;
            skip_c <= SCW'(SKIP);
          end
        end
        W_SKIP: begin
          if (rise) begin
            if (skip_c == SCW'(1)) begin
              // last settling edge is the window reference
              st     <= W_COUNT;
              cnt    <= '0;
              edge_c <= '0;
            end else begin
              skip_c <= skip_c - SCW'(1);
            end
          end
        end
        W_COUNT: begin
          cnt <= cnt + CW'(1);
          if (rise) begin
            if (edge_c == ECW'(WIN - 1)) begin
              fin <= 1'b1;
              val <= cnt + CW'(1);
              st  <= W_IDLE;
            end else begin
              edge_c <= edge_c + ECW'(1);
            end
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R4: counter must not saturate inside a window
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == W_COUNT) |-> (cnt != '1));
  // R4: a finished measurement is reported once
  p_fin_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
endmodule

// File: rtl/loopid_rotate.sv
module loopid_rotate #(
  parameter int NCH = 3,
  parameter int MW  = 4,
  parameter int RW  = 2
) (
  input  logic [NCH*MW-1:0] words,
  input  logic [RW-1:0]     rot,
  output logic [NCH*MW-1:0] drive
);
  for (genvar i = 0; i < NCH; i++) begin : g_chain
    logic [MW-1:0] w_sel;
    always_comb begin
      int src;
      src = i + int'(rot);
      if (src >= NCH) src = src - NCH;
      w_sel = words[src*MW +: MW];
    end
    assign drive[i*MW +: MW] = w_sel;
  end
endmodule

// File: rtl/loopid_cmp.sv
module loopid_cmp #(
  parameter int NCH = 3,
  parameter int CW  = 16,
  parameter int IDW = 3
) (
  input  logic [NCH*CW-1:0] meas,
  output logic [IDW-1:0]    bits
);
  if (NCH == 2) begin : g_pair
    assign bits[0] = meas[0 +: CW] > meas[CW +: CW];
  end else begin : g_ring
    for (genvar k = 0; k < NCH; k++) begin : g_bit
      assign bits[k] = meas[k*CW +: CW] > meas[((k + 1) % NCH)*CW +: CW];
    end
  end
endmodule

// File: rtl/loopid_ctrl.sv
module loopid_ctrl
  import loopid_pkg::*;
#(
  parameter int NCH  = 3,
  parameter int MW   = 4,
  parameter int WIN  = 8,
  parameter int SKIP = 2,
  parameter int CW   = 16,
  parameter int SYNC = 2,
  localparam int IDW = (NCH == 2) ? 1 : NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NCH*MW-1:0] chal,
  input  logic              loop_osc,
  output logic [NCH*MW-1:0] ctrl_words,
  output logic              busy,
  output logic              done,
  output logic [IDW-1:0]    id
);
  localparam int RW = (NCH > 1) ? $clog2(NCH) : 1;

  ctl_st_t           st;
  logic [NCH*MW-1:0] words_q;
  logic [RW-1:0]     rot_q;
  logic [NCH*CW-1:0] meas_q;
  logic              arm_q;
  logic              rise;
  logic              fin;
  logic [CW-1:0]     val;
  logic [IDW-1:0]    id_n;

  loopid_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .osc_async(loop_osc), .rise(rise)
  );

  loopid_window #(.WIN(WIN), .SKIP(SKIP), .CW(CW)) u_win (
    .clk(clk), .rst_n(rst_n), .arm(arm_q), .rise(rise), .fin(fin), .val(val)
  );

  loopid_rotate #(.NCH(NCH), .MW(MW), .RW(RW)) u_rot (
    .words(words_q), .rot(rot_q), .drive(ctrl_words)
  );

  loopid_cmp #(.NCH(NCH), .CW(CW), .IDW(IDW)) u_cmp (
    .meas(meas_q), .bits(id_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= C_IDLE;
      words_q <= '0;
      rot_q   <= '0;
      meas_q  <= '0;
      arm_q   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      id      <= '0;
    end else begin
      arm_q <= 1'b0;
      done  <= 1'b0;
      case (st)
        C_IDLE: begin
          if (start) begin
            words_q <= chal;
            rot_q   <= '0;
            arm_q   <= 1'b1;
            busy    <= 1'b1;
            st      <= C_MEAS;
          end
        end
        C_MEAS: begin
          if (fin) begin
            meas_q[rot_q*CW +: CW] <= val;
            if (rot_q == RW'(NCH - 1)) begin
              st <= C_FIN;
            end else begin
              rot_q <= rot_q + RW'(1);
              arm_q <= 1'b1;
            end
          end
        end
        C_FIN: begin
          id   <= id_n;
          done <= 1'b1;
          busy <= 1'b0;
          st   <= C_IDLE;
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  // R7: done lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: done appears only once busy is low
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7: id moves only with done
  p_id_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(id) |-> done);
  // R3: chain words stay put inside a rotation
  p_words_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(fin)) |-> $stable(ctrl_words));
  // R8: a start during a run leaves the latched challenge alone
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(words_q));
endmodule

// File: tb/loopid_ctrl_bench.sv
`timescale 1ns/1ps
module loopid_ctrl_bench;
  localparam int NCH = 3, MW = 4, WIN = 8, SKIP = 2, CW = 16;
  localparam int W = NCH*MW, N2 = 2, W2 = N2*MW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, start2 = 1'b0;
  logic [W-1:0]  chal = '0;
  logic [W2-1:0] chal2 = '0;
  logic osc = 1'b0, osc2 = 1'b0;
  logic [W-1:0]  ctrl_words;
  logic [W2-1:0] ctrl_words2;
  logic busy, done, busy2, done2;
  logic [NCH-1:0] id;
  logic [0:0] id2;

  int n_chk = 0, n_bad = 0;
  int q3[$], q2[$];
  logic [W-1:0] cur_chal = '0;
  int rot_k = 0;
  logic busy_d = 1'b0;
  int h3, h2, e3, e2;

  always #5 clk = ~clk;

  loopid_ctrl #(.NCH(NCH), .MW(MW), .WIN(WIN), .SKIP(SKIP), .CW(CW)) u_loopid_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .chal(chal), .loop_osc(osc),
    .ctrl_words(ctrl_words), .busy(busy), .done(done), .id(id));

  loopid_ctrl #(.NCH(N2), .MW(MW), .WIN(WIN), .SKIP(SKIP), .CW(CW)) u_loopid_ctrl_pair (
    .clk(clk), .rst_n(rst_n), .start(start2), .chal(chal2), .loop_osc(osc2),
    .ctrl_words(ctrl_words2), .busy(busy2), .done(done2), .id(id2));

  // delay weight of element j in chain i for control bit b
  function automatic int wt(int i, int j, int b);
    return (i*7 + j*3 + b*5 + i*j) % 3;
  endfunction

  // loop period in system clock cycles
  function automatic int per_of(logic [W-1:0] w, int n);
    int p = 4;
    for (int i = 0; i < n; i++)
      for (int j = 0; j < MW; j++)
        p += wt(i, j, int'(w[i*MW + j]));
    return p;
  endfunction

  function automatic logic [W-1:0] rotw(logic [W-1:0] c, int k, int n);
    logic [W-1:0] r = '0;
    for (int i = 0; i < n; i++) r[i*MW +: MW] = c[((i + k) % n)*MW +: MW];
    return r;
  endfunction

  function automatic int exp_id(logic [W-1:0] c, int n);
    int m[NCH];
    int r = 0;
    for (int k = 0; k < n; k++) m[k] = WIN * per_of(rotw(c, k, n), n);
    if (n == 2) r = (m[0] > m[1]) ? 1 : 0;
    else for (int k = 0; k < n; k++) if (m[k] > m[(k + 1) % n]) r |= (1 << k);
    return r;
  endfunction

  // loop models: period follows the applied words
  always begin
    h3 = per_of(ctrl_words, NCH) * 5;
    #(h3);
    osc = ~osc;
  end
  always begin
    h2 = per_of({{(W-W2){1'b0}}, ctrl_words2}, N2) * 5;
    #(h2);
    osc2 = ~osc2;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pop on done, rotation tracking while busy
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (q3.size() == 0) chk(1'b0, "R5 unexpected done", int'(id), -1);
        else begin
          e3 = q3.pop_front();
          chk(int'(id) == e3, "R4,R5 id", int'(id), e3);
        end
      end
      if (done2) begin
        if (q2.size() == 0) chk(1'b0, "R6 unexpected done", int'(id2), -1);
        else begin
          e2 = q2.pop_front();
          chk(int'(id2) == e2, "R6 pair id", int'(id2), e2);
        end
      end
      if (busy) begin
        if (!busy_d) begin
          rot_k = 0;
          chk(ctrl_words == rotw(cur_chal, 0, NCH), "R2 first words",
              int'(ctrl_words), int'(rotw(cur_chal, 0, NCH)));
        end else if (ctrl_words != rotw(cur_chal, rot_k, NCH)) begin
          rot_k++;
          chk(rot_k < NCH && ctrl_words == rotw(cur_chal, rot_k, NCH), "R3 rotation",
              int'(ctrl_words), int'(rotw(cur_chal, rot_k, NCH)));
        end
      end
      busy_d = busy;
    end
  end

  task automatic run3(input logic [W-1:0] c, input bit poke, input logic [W-1:0] other);
    int e = exp_id(c, NCH);
    q3.push_back(e);
    cur_chal = c;
    @(negedge clk);
    start = 1'b1; chal = c;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy rises", int'(busy), 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      start = 1'b1; chal = other;   // R8: must be dropped
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(busy == 1'b0, "R7 busy low at done", int'(busy), 0);
    repeat (4) @(negedge clk);
    chk(int'(id) == e && !done, "R7 id holds", int'(id), e);
  endtask

  task automatic run2(input logic [W2-1:0] c);
    q2.push_back(exp_id({{(W-W2){1'b0}}, c}, N2));
    @(negedge clk);
    start2 = 1'b1; chal2 = c;
    @(negedge clk);
    start2 = 1'b0;
    while (!done2) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && id == 0 && ctrl_words == 0, "R1 reset state",
        int'({busy, done, id}), 0);
    chk(busy2 == 0 && id2 == 0 && ctrl_words2 == 0, "R1 reset state pair",
        int'({busy2, id2}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run3({4'h3, 4'hA, 4'h5}, 1'b0, '0);
    run3({4'h0, 4'h0, 4'hF}, 1'b0, '0);
    run3({4'h9, 4'h6, 4'hC}, 1'b0, '0);
    run3({4'hE, 4'h1, 4'h7}, 1'b0, '0);
    // R5 equal measurements give zero bits
    chk(exp_id({4'h5, 4'h5, 4'h5}, NCH) == 0, "R5 equal model", exp_id({4'h5, 4'h5, 4'h5}, NCH), 0);
    run3({4'h5, 4'h5, 4'h5}, 1'b0, '0);
    // R8 start while busy
    run3({4'h2, 4'hD, 4'h8}, 1'b1, {4'hF, 4'h0, 4'h1});
    run3({4'h6, 4'h3, 4'hB}, 1'b0, '0);
    // R6 two-chain variant
    run2({4'h1, 4'hE});
    run2({4'h7, 4'h0});
    run2({4'hC, 4'h3});
    chk(q3.size() == 0 && q2.size() == 0, "R7 all results delivered",
        q3.size() + q2.size(), 0);
    finish_up();
  end
endmodule